// File: doc/BRIEF.md
# Watchdog and Supply Reset Supervisor

This block drives the reset line of a small processor. Three causes can hold that line asserted. The first is the power-on interval that follows release of the block's own asynchronous reset. The second is a low-supply indication from an external comparator. The third is a watchdog that the processor failed to restart in time. The reset output comes in an active-low variant and an active-high variant, chosen by a parameter.

The watchdog restart uses the chip-select line of the serial memory bus. A falling edge restarts the count, but only if the line was high for long enough beforehand. A two-bit code sets the watchdog interval. That code is held outside the block in nonvolatile storage and feeds in as a static input. One code value turns the watchdog off. A volatile flag records that a watchdog expiry caused the last reset, so that software can tell it apart from a supply dip. Software clears the flag by writing zero through a simple write strobe.

All intervals are counted in pulses of an external enable tick (nominally 1 kHz). The counts are parameters, so a bench can shorten them. The low-supply input is assumed to be already synchronous to `clk`. The chip-select input is synchronised inside the block.

Top module: `supv_reset_ctl`

## Requirements
- R1: After `rst_n` releases, reset stays asserted until POR_TICKS tick pulses have been seen, and it releases on the clock edge that samples the last of them. Asserting `rst_n` asserts reset at once.
- R2: While `low_supply_i` is 1, reset is asserted from the next clock edge. Once `low_supply_i` returns to 0, reset stays asserted for RST_TICKS further ticks and releases on the edge of the last one.
- R3: `wd_code_i` selects the watchdog interval: 2'b10 gives WD_SHORT ticks, 2'b01 gives WD_MID ticks and 2'b00 gives WD_LONG ticks. These are counted from reset release or from the last restart. Reset asserts on the edge of the final tick.
- R4: Code 2'b11 disables the watchdog, so no number of ticks causes a watchdog reset.
- R5: A falling edge of `wdi_i` restarts the watchdog count only if `wdi_i` was sampled high on at least KICK_MIN consecutive clock edges before it fell. A shorter high pulse is ignored.
- R6: A watchdog expiry holds reset for RST_TICKS ticks. After release the watchdog counts a full interval again from zero.
- R7: `wd_flag_o` goes to 1 on a watchdog expiry. It is cleared by `rst_n` and by a write with `flag_wr_i`=1 and `flag_wdata_i`=0. A write of 1 has no effect, and a low-supply reset does not clear it.
- R8: When a qualified restart and the tick that would end the interval fall on the same clock edge, the restart wins. No reset occurs, and a new full interval begins.
- R9: When an expiry and a clearing write fall on the same clock edge, the flag ends up set.
- R10: With RST_ACTIVE_HIGH=0, `rst_o` is 0 while reset is asserted. With RST_ACTIVE_HIGH=1, it is 1 while reset is asserted.
- R11: The watchdog does not count while reset is asserted for any reason, so ticks during a reset never cause an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the block |
| tick_i | input | 1 | One-cycle time-base enable pulse (nominally 1 kHz) |
| low_supply_i | input | 1 | Low-supply indication, 1 = supply below trip level |
| wdi_i | input | 1 | Chip-select line used as watchdog restart input |
| wd_code_i | input | 2 | Watchdog interval code from nonvolatile storage |
| flag_wr_i | input | 1 | Write strobe for the watchdog cause flag |
| flag_wdata_i | input | 1 | Write data for the cause flag (0 clears) |
| rst_o | output | 1 | Reset output, polarity set by RST_ACTIVE_HIGH |
| wd_flag_o | output | 1 | Volatile flag: last reset caused by watchdog |

## Verification
Two pairs of events can land on the same clock edge. A restart can coincide with the tick that would end the interval, and an expiry can coincide with a software write that clears the flag. The bench provokes the first by dropping `wdi_i` two edges before it raises the final tick, since the restart needs two synchroniser stages to arrive. It judges the result by checking that reset stays released for one more full interval and then fires on exactly its last tick. The second is provoked by raising the clearing write together with that final tick, and it passes only if the flag reads 1 afterwards.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    WDC_LONG  = 2'b00,
    WDC_MID   = 2'b01,
    WDC_SHORT = 2'b10,
    WDC_OFF   = 2'b11
  } wd_code_e;

  typedef enum logic [1:0] {
    ST_POR,
    ST_LOW,
    ST_HOLD,
    ST_RUN
  } rst_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int cnt_width(input int max_count);
    return $clog2(max_count + 1);
  endfunction

endpackage

// File: rtl/supv_kick_filter.sv
module supv_kick_filter #(
  parameter int KICK_MIN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi_i,
  output logic kick_o
);
  localparam int HW = supv_pkg::cnt_width(KICK_MIN);
  localparam logic [HW-1:0] HI_FULL = HW'(KICK_MIN);

  logic          sync1_q, sync2_q;
  logic [HW-1:0] hi_cnt_q, hi_cnt_d;

  always_comb begin
    hi_cnt_d = hi_cnt_q;
    if (!sync2_q) begin
      hi_cnt_d = '0;
    end else if (hi_cnt_q != HI_FULL) begin
      hi_cnt_d = hi_cnt_q + 1'b1;
    end
  end

  // restart on the first low sample after a long enough high run
  assign kick_o = !sync2_q && (hi_cnt_q == HI_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q  <= 1'b0;
      sync2_q  <= 1'b0;
      hi_cnt_q <= '0;
    end else begin
      sync1_q  <= wdi_i;
      sync2_q  <= sync1_q;
      hi_cnt_q <= hi_cnt_d;
    end
  end
endmodule

// File: rtl/supv_wd_timer.sv
module supv_wd_timer #(
  parameter int WD_SHORT = 200,
  parameter int WD_MID   = 600,
  parameter int WD_LONG  = 1400,
  localparam int CW      = supv_pkg::cnt_width(supv_pkg::max3(WD_SHORT, WD_MID, WD_LONG))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [1:0]    code_i,
  input  logic          hold_i,
  input  logic          kick_i,
  output logic          expire_o,
  output logic [CW-1:0] count_o
);
  import supv_pkg::*;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_val;
  logic          enabled;

  always_comb begin
    case (wd_code_e'(code_i))
      WDC_SHORT: last_val = CW'(WD_SHORT - 1);
      WDC_MID:   last_val = CW'(WD_MID - 1);
      default:   last_val = CW'(WD_LONG - 1);
    endcase
  end

  assign enabled  = (wd_code_e'(code_i) != WDC_OFF);
  assign expire_o = !hold_i && tick_i && !kick_i && enabled && (cnt_q >= last_val);

  always_comb begin
    cnt_d = cnt_q;
    if (hold_i || kick_i || expire_o || !enabled) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/supv_rst_seq.sv
module supv_rst_seq #(
  parameter int POR_TICKS = 200,
  parameter int RST_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic low_i,
  input  logic wd_expire_i,
  output logic rst_act_o
);
  import supv_pkg::*;

  localparam int HW = cnt_width((POR_TICKS > RST_TICKS) ? POR_TICKS : RST_TICKS);
  localparam logic [HW-1:0] POR_LAST = HW'(POR_TICKS - 1);
  localparam logic [HW-1:0] RST_LAST = HW'(RST_TICKS - 1);

  rst_state_e    state_q, state_d;
  logic [HW-1:0] cnt_q, cnt_d;
  logic          act_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_POR: begin
        if (low_i) begin
          state_d = ST_LOW;
          cnt_d   = '0;
        end else if (tick_i) begin
          if (cnt_q == POR_LAST) begin
            state_d = ST_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_LOW: begin
        cnt_d = '0;
        if (!low_i) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (low_i) begin
          state_d = ST_LOW;
          cnt_d   = '0;
        end else if (tick_i) begin
          if (cnt_q == RST_LAST) begin
            state_d = ST_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        if (low_i) begin
          state_d = ST_LOW;
        end else if (wd_expire_i) begin
          state_d = ST_HOLD;
        end
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POR;
      cnt_q   <= '0;
      act_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      act_q   <= (state_d != ST_RUN);
    end
  end

  assign rst_act_o = act_q;
endmodule

// File: rtl/supv_reset_ctl.sv
module supv_reset_ctl #(
  parameter int POR_TICKS       = 200,
  parameter int RST_TICKS       = 200,
  parameter int WD_SHORT        = 200,
  parameter int WD_MID          = 600,
  parameter int WD_LONG         = 1400,
  parameter int KICK_MIN        = 20,
  parameter bit RST_ACTIVE_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       low_supply_i,
  input  logic       wdi_i,
  input  logic [1:0] wd_code_i,
  input  logic       flag_wr_i,
  input  logic       flag_wdata_i,
  output logic       rst_o,
  output logic       wd_flag_o
);
  localparam int WD_W = supv_pkg::cnt_width(supv_pkg::max3(WD_SHORT, WD_MID, WD_LONG));

  logic            rst_q;
  logic            wd_kick;
  logic            wd_expire;
  logic [WD_W-1:0] wd_count;
  logic            flag_q, flag_d;

  supv_kick_filter #(.KICK_MIN(KICK_MIN)) u_kick (
    .clk    (clk),
    .rst_n  (rst_n),
    .wdi_i  (wdi_i),
    .kick_o (wd_kick)
  );

  supv_wd_timer #(
    .WD_SHORT (WD_SHORT),
    .WD_MID   (WD_MID),
    .WD_LONG  (WD_LONG)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .code_i   (wd_code_i),
    .hold_i   (rst_q),
    .kick_i   (wd_kick),
    .expire_o (wd_expire),
    .count_o  (wd_count)
  );

  supv_rst_seq #(
    .POR_TICKS (POR_TICKS),
    .RST_TICKS (RST_TICKS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .low_i       (low_supply_i),
    .wd_expire_i (wd_expire),
    .rst_act_o   (rst_q)
  );

  // expiry has priority over a clearing write
  always_comb begin
    flag_d = flag_q;
    if (wd_expire) begin
      flag_d = 1'b1;
    end else if (flag_wr_i && !flag_wdata_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign wd_flag_o = flag_q;

  generate
    if (RST_ACTIVE_HIGH) begin : g_pol_high
      assign rst_o = rst_q;
    end else begin : g_pol_low
      assign rst_o = ~rst_q;
    end
  endgenerate
endmodule

// File: rtl/supv_reset_ctl_chk.sv
module supv_reset_ctl_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             low_supply_i,
  input logic [1:0]       wd_code_i,
  input logic             flag_wr_i,
  input logic             flag_wdata_i,
  input logic             wd_flag_o,
  input logic             rst_q,
  input logic             wd_kick,
  input logic             wd_expire,
  input logic [CNT_W-1:0] wd_count
);

  a_r2_low_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
    low_supply_i |=> rst_q);

  a_r1_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> $past(tick_i));

  a_r11_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && $past(rst_q)) |-> (wd_count == '0));

  a_r4_off_no_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_code_i == 2'b11) |-> !wd_expire);

  a_r8_kick_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    wd_kick |-> !wd_expire);

  a_r7_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> wd_flag_o);

  a_r7_write_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_i && !flag_wdata_i && !wd_expire) |=> !wd_flag_o);

endmodule

bind supv_reset_ctl supv_reset_ctl_chk #(.CNT_W(WD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_i       (tick_i),
  .low_supply_i (low_supply_i),
  .wd_code_i    (wd_code_i),
  .flag_wr_i    (flag_wr_i),
  .flag_wdata_i (flag_wdata_i),
  .wd_flag_o    (wd_flag_o),
  .rst_q        (rst_q),
  .wd_kick      (wd_kick),
  .wd_expire    (wd_expire),
  .wd_count     (wd_count)
);

// File: tb/supv_reset_ctl_bench.sv
module supv_reset_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int POR  = 5;
  localparam int RST  = 4;
  localparam int WS   = 6;
  localparam int WM   = 9;
  localparam int WL   = 12;
  localparam int KMIN = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i;
  logic       low_supply_i;
  logic       wdi_i;
  logic [1:0] wd_code_i;
  logic       flag_wr_i;
  logic       flag_wdata_i;
  logic       rst_lo, rst_hi, flag_lo, flag_hi;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  supv_reset_ctl #(
    .POR_TICKS(POR), .RST_TICKS(RST), .WD_SHORT(WS), .WD_MID(WM), .WD_LONG(WL),
    .KICK_MIN(KMIN), .RST_ACTIVE_HIGH(1'b0)
  ) u_supv_reset_ctl (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .low_supply_i(low_supply_i),
    .wdi_i(wdi_i), .wd_code_i(wd_code_i), .flag_wr_i(flag_wr_i),
    .flag_wdata_i(flag_wdata_i), .rst_o(rst_lo), .wd_flag_o(flag_lo)
  );

  supv_reset_ctl #(
    .POR_TICKS(POR), .RST_TICKS(RST), .WD_SHORT(WS), .WD_MID(WM), .WD_LONG(WL),
    .KICK_MIN(KMIN), .RST_ACTIVE_HIGH(1'b1)
  ) u_supv_reset_ctl_hi (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .low_supply_i(low_supply_i),
    .wdi_i(wdi_i), .wd_code_i(wd_code_i), .flag_wr_i(flag_wr_i),
    .flag_wdata_i(flag_wdata_i), .rst_o(rst_hi), .wd_flag_o(flag_hi)
  );

  task automatic cyc(input logic t);
    tick_i = t;
    @(posedge clk);
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic tk();
    cyc(1'b1);
    cyc(1'b0);
  endtask

  // R10: both polarity variants are judged against the same expectation
  task automatic chk_rst(input string req, input logic exp_asserted);
    total++;
    if (rst_lo !== ~exp_asserted || rst_hi !== exp_asserted) begin
      bad++;
      $display("FAIL %s/R10 reset: lo=%b hi=%b expected lo=%b hi=%b",
               req, rst_lo, rst_hi, ~exp_asserted, exp_asserted);
    end
  endtask

  task automatic chk_flag(input string req, input logic exp);
    total++;
    if (flag_lo !== exp || flag_hi !== exp) begin
      bad++;
      $display("FAIL %s flag: got %b/%b expected %b", req, flag_lo, flag_hi, exp);
    end
  endtask

  task automatic kick();
    wdi_i = 1'b0;
    repeat (3) cyc(1'b0);
    wdi_i = 1'b1;
    repeat (KMIN + 1) cyc(1'b0);
  endtask

  task automatic pulse(input int h);
    wdi_i = 1'b1;
    repeat (h) cyc(1'b0);
    wdi_i = 1'b0;
    repeat (3) cyc(1'b0);
  endtask

  task automatic hold_release(input string req);
    for (int i = 1; i <= RST; i++) begin
      tk();
      chk_rst(req, i < RST);
    end
  endtask

  task automatic wclr();
    flag_wr_i = 1'b1;
    flag_wdata_i = 1'b0;
    cyc(1'b0);
    flag_wr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lim;
    rst_n = 1'b0;
    tick_i = 1'b0;
    low_supply_i = 1'b0;
    wdi_i = 1'b1;
    wd_code_i = 2'b11;
    flag_wr_i = 1'b0;
    flag_wdata_i = 1'b0;
    repeat (3) @(negedge clk);
    chk_rst("R1", 1'b1);
    chk_flag("R7", 1'b0);
    rst_n = 1'b1;

    // R1 power-on sweep
    for (int i = 1; i <= POR; i++) begin
      tk();
      chk_rst("R1", i < POR);
    end

    // R2 low supply, R11 no counting during reset
    wd_code_i = 2'b10;
    low_supply_i = 1'b1;
    cyc(1'b0);
    chk_rst("R2", 1'b1);
    repeat (2 * WS) tk();
    chk_rst("R2", 1'b1);
    chk_flag("R11", 1'b0);
    low_supply_i = 1'b0;
    cyc(1'b0);
    chk_rst("R2", 1'b1);
    hold_release("R2");

    // R3 interval sweep over the three active codes, R6 recount
    for (int c = 0; c < 3; c++) begin
      case (c)
        0: begin wd_code_i = 2'b10; lim = WS; end
        1: begin wd_code_i = 2'b01; lim = WM; end
        default: begin wd_code_i = 2'b00; lim = WL; end
      endcase
      kick();
      for (int i = 1; i <= lim; i++) begin
        tk();
        chk_rst("R3", i == lim);
      end
      chk_flag("R7", 1'b1);
      hold_release("R6");
      if (c == 0) begin
        for (int i = 1; i <= lim; i++) begin
          tk();
          chk_rst("R6", i == lim);
        end
        hold_release("R6");
      end
      wclr();
      chk_flag("R7", 1'b0);
    end

    // R5 short pulse ignored, long pulse restarts
    wd_code_i = 2'b10;
    wdi_i = 1'b0;
    repeat (4) cyc(1'b0);
    repeat (4) tk();
    pulse(KMIN - 1);
    tk();
    chk_rst("R5", 1'b0);
    tk();
    chk_rst("R5", 1'b1);
    hold_release("R5");
    repeat (4) tk();
    pulse(KMIN);
    repeat (WS - 1) tk();
    chk_rst("R5", 1'b0);
    tk();
    chk_rst("R5", 1'b1);
    hold_release("R5");
    wdi_i = 1'b1;
    repeat (KMIN + 1) cyc(1'b0);
    wclr();

    // R8 restart on the final tick edge, R9 expiry vs clearing write
    kick();
    repeat (WS - 1) tk();
    wdi_i = 1'b0;
    cyc(1'b0);
    cyc(1'b0);
    cyc(1'b1);
    chk_rst("R8", 1'b0);
    wdi_i = 1'b1;
    repeat (KMIN + 1) cyc(1'b0);
    repeat (WS - 1) tk();
    chk_rst("R8", 1'b0);
    flag_wr_i = 1'b1;
    flag_wdata_i = 1'b0;
    cyc(1'b1);
    flag_wr_i = 1'b0;
    chk_rst("R8", 1'b1);
    chk_flag("R9", 1'b1);

    // R7 low supply keeps the flag, write of one does nothing
    low_supply_i = 1'b1;
    cyc(1'b0);
    low_supply_i = 1'b0;
    cyc(1'b0);
    chk_flag("R7", 1'b1);
    hold_release("R2");
    wclr();
    chk_flag("R7", 1'b0);
    flag_wr_i = 1'b1;
    flag_wdata_i = 1'b1;
    cyc(1'b0);
    flag_wr_i = 1'b0;
    chk_flag("R7", 1'b0);

    // R4 disabled code
    wd_code_i = 2'b11;
    repeat (2 * WL) tk();
    chk_rst("R4", 1'b0);
    chk_flag("R4", 1'b0);

    // R7 power-on clears the flag
    wd_code_i = 2'b10;
    repeat (WS) tk();
    chk_rst("R3", 1'b1);
    chk_flag("R7", 1'b1);
    rst_n = 1'b0;
    cyc(1'b0);
    chk_flag("R7", 1'b0);
    chk_rst("R1", 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule